// File: doc/BRIEF.md
# Single-Cycle Processor Core with Hardware Multiply

This block is a small processor that finishes one 32-bit instruction on every enabled clock edge. It holds a program counter, a 32-entry register file, a main instruction decoder and a function-code decoder for the ALU. The ALU also contains a full-width combinational multiplier. The instruction store and the data store are word-organised arrays inside the core. The data store reads combinationally and writes on the clock edge. The instruction store is loaded from outside the block by hierarchical access while the core is held idle.

The core has a clock, an active-low asynchronous reset and a global enable. While enable is low, every piece of state holds its value. Debug outputs show the current program counter and the register-file write port of the instruction that is executing. A surrounding test environment can therefore follow the architectural state without reaching inside the core. Multiplication is an ordinary register-to-register instruction: the low 32 bits of the product go directly to the destination register in the same cycle.

Top module: `cpu_core`

## Requirements
- R1: While arstN is low, the PC, all 32 registers and every data-store word are cleared to zero. After release, pcOut reads 0 and any register or data word that has not been written reads 0.
- R2: An instruction with opcode 000000 is register-to-register. It reads rs from bits [25:21] and rt from bits [20:16], and writes rd (bits [15:11]) in the same cycle. The function code in bits [5:0] selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than (result 1 or 0), and 000000 shift rt left by the amount in bits [10:6].
- R3: Function code 011000 under opcode 000000 writes the low 32 bits of the signed product rs × rt to rd in one cycle. Overflow is discarded silently.
- R4: Opcode 001000 writes rs plus the sign-extended 16-bit immediate (bits [15:0]) to rt.
- R5: Opcode 100011 loads the data word at byte address rs + sign-extended immediate (word index = address bits above bit 1) into rt. Opcode 101011 stores rt at that address and writes no register.
- R6: Opcode 000100 sets the next PC to PC+4 + (sign-extended immediate << 2) when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 000010 sets the next PC to {PC+4[31:28], bits [25:0], 2'b00}. The PC is always a multiple of 4.
- R8: Register 0 always reads as zero. A write addressed to register 0 leaves it at zero.
- R9: While enable is low, the PC, the registers and the data store keep their values, and dbgWe stays low.
- R10: Any opcode other than those above behaves as a no-operation: no register write, no store, and the next PC is PC+4. The all-zero word is a shift that writes register 0 and has no visible effect.
- R11: pcOut shows the PC of the executing instruction. When enable is high and the instruction writes a register, dbgWe is high and dbgWaddr and dbgWdata show the destination and the value committed at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| arstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global advance enable; low freezes all state |
| pcOut | output | 32 | Address of the instruction currently executing |
| dbgWe | output | 1 | Register-file write strobe of the current instruction |
| dbgWaddr | output | 5 | Destination register of the current write |
| dbgWdata | output | 32 | Value being written to the register file |

## Verification
The main stimulus is a looping program that loads five operand pairs and multiplies each pair in hardware. The pairs are chosen with mixed signs, a zero-overflow case (65536 × 65536) and a product that wraps past 2^31. A wrong sign, width or truncation in the multiplier therefore gives a different accumulated total. The loop exits through a taken branch and returns through a jump after several branches that are not taken, so the target arithmetic of both branch and jump is tested in each direction. After the loop, the accumulated value is stored and reloaded, then passed through subtract, AND, OR, signed compare and shift. This separates those function codes from one another on a negative operand. It is followed by a write to register 0, an unknown opcode and a period with enable held low, which show whether ignored stimulus leaks into the observable state.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int XLEN     = 32;
  localparam int REG_CNT  = 32;
  localparam int REG_AW   = $clog2(REG_CNT);
  localparam int SHAMT_W  = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_JUMP  = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_MUL = 6'b011000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_MUL
  } aluSel_e;

  typedef enum logic [1:0] {
    CLS_ADD, CLS_SUB, CLS_FUNCT
  } aluClass_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrcImm;
    logic    memToReg;
    logic    regWrite;
    logic    memWrite;
    logic    branch;
    logic    jump;
    aluSel_e aluSel;
  } ctrl_t;

endpackage

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  aluClass_e aluClass;
  ctrl_t     mainDec;
  aluSel_e   aluSel;

  // Main decoder: looks at the opcode only.
  always_comb begin
    mainDec  = '0;
    aluClass = CLS_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        mainDec.regDst   = 1'b1;
        mainDec.regWrite = 1'b1;
        aluClass         = CLS_FUNCT;
      end
      OP_ADDI: begin
        mainDec.aluSrcImm = 1'b1;
        mainDec.regWrite  = 1'b1;
      end
      OP_LOAD: begin
        mainDec.aluSrcImm = 1'b1;
        mainDec.memToReg  = 1'b1;
        mainDec.regWrite  = 1'b1;
      end
      OP_STORE: begin
        mainDec.aluSrcImm = 1'b1;
        mainDec.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        mainDec.branch = 1'b1;
        aluClass       = CLS_SUB;
      end
      OP_JUMP: begin
        mainDec.jump = 1'b1;
      end
      default: begin
        mainDec = '0;
      end
    endcase
  end

  // ALU control: refines the operation class with the function code.
  always_comb begin
    aluSel = ALU_ADD;
    case (aluClass)
      CLS_SUB: aluSel = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_ADD:  aluSel = ALU_ADD;
          FN_SUB:  aluSel = ALU_SUB;
          FN_AND:  aluSel = ALU_AND;
          FN_OR:   aluSel = ALU_OR;
          FN_SLT:  aluSel = ALU_SLT;
          FN_SLL:  aluSel = ALU_SLL;
          FN_MUL:  aluSel = ALU_MUL;
          default: aluSel = ALU_ADD;
        endcase
      end
      default: aluSel = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl        = mainDec;
    ctrl.aluSel = aluSel;
  end

  always_comb begin
    if (!$isunknown(opcode)) begin
      AST_STORE_NO_WB: assert (!(ctrl.memWrite && ctrl.regWrite)); // R5
      AST_FLOW_EXCL: assert ($onehot0({ctrl.branch, ctrl.jump, ctrl.memWrite, ctrl.regWrite})); // R10
    end
  end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SHAMT_W-1:0] shamt,
  input  aluSel_e            sel,
  output logic [DATA_W-1:0]  result,
  output logic               isZero
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prodFull;

  // Single-cycle signed multiplier; only the low half is kept.
  assign prodFull = $signed({{DATA_W{opA[DATA_W-1]}}, opA}) *
                    $signed({{DATA_W{opB[DATA_W-1]}}, opB});

  always_comb begin
    case (sel)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(DATA_W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_SLL: result = opB << shamt;
      ALU_MUL: result = prodFull[DATA_W-1:0];
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int DEPTH  = REG_CNT
) (
  input  logic                     clk,
  input  logic                     arstN,
  input  logic                     enable,
  input  logic                     wrEn,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [$clog2(DEPTH)-1:0] rdAddrA,
  input  logic [$clog2(DEPTH)-1:0] rdAddrB,
  output logic [DATA_W-1:0]        rdDataA,
  output logic [DATA_W-1:0]        rdDataB
);

  logic [DATA_W-1:0] regArr [DEPTH];

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      for (int i = 0; i < DEPTH; i++) regArr[i] <= '0;
    end else if (enable && wrEn && (wrAddr != '0)) begin
      regArr[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regArr[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regArr[rdAddrB];

  AST_ZERO_REG_CLEAN: assert property (@(posedge clk) disable iff (!arstN)
    regArr[0] == '0); // R8

  AST_REG_FROZEN: assert property (@(posedge clk) disable iff (!arstN)
    !enable |=> $stable(regArr[1])); // R9

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              enable,
  input  ctrl_t             ctrl,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic [XLEN-1:0]   pcOut,
  output logic              dbgWe,
  output logic [REG_AW-1:0] dbgWaddr,
  output logic [XLEN-1:0]   dbgWdata
);

  localparam int IMEM_AW = $clog2(IMEM_DEPTH);
  localparam int DMEM_AW = $clog2(DMEM_DEPTH);
  localparam int IMM_W   = 16;

  logic [XLEN-1:0] imemArr [IMEM_DEPTH];
  logic [XLEN-1:0] dmemArr [DMEM_DEPTH];

  logic [XLEN-1:0]    pcQ, pcNext, pcPlus4, brTarget, jmpTarget;
  logic [XLEN-1:0]    instr;
  logic [REG_AW-1:0]  rsIdx, rtIdx, rdIdx, wrIdx;
  logic [SHAMT_W-1:0] shamt;
  logic [IMM_W-1:0]   imm;
  logic [XLEN-1:0]    immExt, rsVal, rtVal, aluB, aluRes, memRd, wbData;
  logic               aluZero, brTaken, rfWe;
  logic [DMEM_AW-1:0] dmemIdx;

  // Fetch and field split.
  assign instr  = imemArr[pcQ[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign immExt = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  cpu_regfile #(.DATA_W(XLEN), .DEPTH(REG_CNT)) rfI (
    .clk     (clk),
    .arstN   (arstN),
    .enable  (enable),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrIdx),
    .wrData  (wbData),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (rsVal),
    .rdDataB (rtVal)
  );

  assign aluB = ctrl.aluSrcImm ? immExt : rtVal;

  cpu_alu #(.DATA_W(XLEN)) aluI (
    .opA    (rsVal),
    .opB    (aluB),
    .shamt  (shamt),
    .sel    (ctrl.aluSel),
    .result (aluRes),
    .isZero (aluZero)
  );

  // Data store: combinational read, edge write.
  assign dmemIdx = aluRes[DMEM_AW+1:2];
  assign memRd   = dmemArr[dmemIdx];

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      for (int i = 0; i < DMEM_DEPTH; i++) dmemArr[i] <= '0;
    end else if (enable && ctrl.memWrite) begin
      dmemArr[dmemIdx] <= rtVal;
    end
  end

  // Instruction store: cleared by reset, loaded from outside while idle.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      for (int i = 0; i < IMEM_DEPTH; i++) imemArr[i] <= '0;
    end
  end

  assign wbData = ctrl.memToReg ? memRd : aluRes;
  assign wrIdx  = ctrl.regDst ? rdIdx : rtIdx;
  assign rfWe   = enable && ctrl.regWrite;

  // Next-PC selection.
  assign pcPlus4   = pcQ + XLEN'(4);
  assign brTarget  = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jmpTarget = {pcPlus4[XLEN-1:28], instr[25:0], 2'b00};
  assign brTaken   = ctrl.branch && aluZero;

  always_comb begin
    if (ctrl.jump)   pcNext = jmpTarget;
    else if (brTaken) pcNext = brTarget;
    else             pcNext = pcPlus4;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)      pcQ <= '0;
    else if (enable) pcQ <= pcNext;
  end

  assign pcOut    = pcQ;
  assign dbgWe    = rfWe;
  assign dbgWaddr = wrIdx;
  assign dbgWdata = wbData;

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!arstN)
    !enable |=> $stable(pcQ)); // R9

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!arstN)
    pcQ[1:0] == 2'b00); // R7

  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!arstN)
    (enable && ctrl.jump) |=> (pcQ[27:0] == {$past(instr[25:0]), 2'b00})); // R7

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!arstN)
    (enable && !ctrl.jump && !ctrl.branch) |=> (pcQ == $past(pcQ) + XLEN'(4))); // R10

  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (!arstN)
    (enable && ctrl.memWrite) |-> !dbgWe); // R5

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic        clk,
  input  logic        arstN,
  input  logic        enable,
  output logic [31:0] pcOut,
  output logic        dbgWe,
  output logic [4:0]  dbgWaddr,
  output logic [31:0] dbgWdata
);

  ctrl_t      ctrlBus;
  logic [5:0] opcode;
  logic [5:0] funct;

  cpu_ctrl ctrlI (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrlBus)
  );

  cpu_datapath #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) dpathI (
    .clk      (clk),
    .arstN    (arstN),
    .enable   (enable),
    .ctrl     (ctrlBus),
    .opcode   (opcode),
    .funct    (funct),
    .pcOut    (pcOut),
    .dbgWe    (dbgWe),
    .dbgWaddr (dbgWaddr),
    .dbgWdata (dbgWdata)
  );

endmodule

// File: tb/cpu_core_tb.sv
module cpu_core_tb_top;

  logic        clk = 1'b0;
  logic        arstN;
  logic        enable;
  logic [31:0] pcOut;
  logic        dbgWe;
  logic [4:0]  dbgWaddr;
  logic [31:0] dbgWdata;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  cpu_core dut_i (
    .clk      (clk),
    .arstN    (arstN),
    .enable   (enable),
    .pcOut    (pcOut),
    .dbgWe    (dbgWe),
    .dbgWaddr (dbgWaddr),
    .dbgWdata (dbgWdata)
  );

  // Reference state, kept behaviourally.
  logic [31:0] mReg  [32];
  logic [31:0] mMem  [64];
  logic [31:0] mImem [64];
  logic [31:0] mPc;
  logic [31:0] seen  [32];  // register values observed on the debug port

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] encJ(int target);
    return {6'b000010, 26'(target)};
  endfunction

  function automatic string reqOf(logic [31:0] ins);
    case (ins[31:26])
      6'b000000: return (ins[5:0] == 6'b011000) ? "R3" : "R2";
      6'b001000: return "R4";
      6'b100011, 6'b101011: return "R5";
      6'b000100: return "R6";
      6'b000010: return "R7";
      default:   return "R10";
    endcase
  endfunction

  // Predict what the instruction at mPc does.
  task automatic predict(output bit we, output logic [4:0] wa, output logic [31:0] wd,
                         output logic [31:0] npc, output logic [31:0] ins);
    logic [31:0] a, b, se, addr;
    ins  = mImem[mPc[7:2]];
    a    = mReg[ins[25:21]];
    b    = mReg[ins[20:16]];
    se   = {{16{ins[15]}}, ins[15:0]};
    addr = a + se;
    npc  = mPc + 32'd4;
    we = 0; wa = '0; wd = '0;
    case (ins[31:26])
      6'b000000: begin
        we = 1; wa = ins[15:11];
        case (ins[5:0])
          6'b100010: wd = a - b;
          6'b100100: wd = a & b;
          6'b100101: wd = a | b;
          6'b101010: wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          6'b000000: wd = b << ins[10:6];
          6'b011000: wd = a * b;
          default:   wd = a + b;
        endcase
      end
      6'b001000: begin we = 1; wa = ins[20:16]; wd = addr; end
      6'b100011: begin we = 1; wa = ins[20:16]; wd = mMem[addr[7:2]]; end
      6'b000100: if (a == b) npc = mPc + 32'd4 + (se << 2);
      6'b000010: npc = {npc[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
  endtask

  task automatic modelStep();
    bit we; logic [4:0] wa; logic [31:0] wd, npc, ins, addr;
    predict(we, wa, wd, npc, ins);
    addr = mReg[ins[25:21]] + {{16{ins[15]}}, ins[15:0]};
    if (we && wa != 0) mReg[wa] = wd;
    if (ins[31:26] == 6'b101011) mMem[addr[7:2]] = mReg[ins[20:16]];
    mPc = npc;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] prog [64];
    int pairs [10];
    int expSum, lastProd;

    for (int i = 0; i < 64; i++) begin prog[i] = '0; mMem[i] = '0; end
    for (int i = 0; i < 32; i++) begin mReg[i] = '0; seen[i] = '0; end
    mPc = '0;

    pairs = '{3, 7, -4, 5, 12, -6, 65536, 65536, 100000, 30000};
    expSum = 0; lastProd = 0;
    for (int i = 0; i < 5; i++) begin
      lastProd = pairs[2*i] * pairs[2*i+1];
      expSum   = expSum + lastProd;
    end

    prog[0]  = encR(5, 6, 14, 0, 6'b100101);        // or  r14,r5,r6 (reset values)
    prog[1]  = encI(6'b100011, 0, 15, 80);          // lw  r15,80(r0) unloaded word
    prog[2]  = encI(6'b001000, 0, 1, 0);            // addi r1,r0,0
    prog[3]  = encI(6'b001000, 0, 2, 5);            // addi r2,r0,5
    prog[4]  = encI(6'b001000, 0, 3, 0);            // addi r3,r0,0
    prog[5]  = encI(6'b000100, 2, 0, 7);            // beq r2,r0,+7 -> 52
    prog[6]  = encI(6'b100011, 1, 4, 0);            // lw  r4,0(r1)
    prog[7]  = encI(6'b100011, 1, 5, 4);            // lw  r5,4(r1)
    prog[8]  = encR(4, 5, 6, 0, 6'b011000);         // mult r6,r4,r5
    prog[9]  = encR(3, 6, 3, 0, 6'b100000);         // add r3,r3,r6
    prog[10] = encI(6'b001000, 1, 1, 8);            // addi r1,r1,8
    prog[11] = encI(6'b001000, 2, 2, -1);           // addi r2,r2,-1
    prog[12] = encJ(5);                             // j 20
    prog[13] = encI(6'b101011, 0, 3, 40);           // sw  r3,40(r0)
    prog[14] = encI(6'b100011, 0, 7, 40);           // lw  r7,40(r0)
    prog[15] = encR(0, 7, 8, 0, 6'b100010);         // sub r8,r0,r7
    prog[16] = encR(7, 8, 9, 0, 6'b100100);         // and r9,r7,r8
    prog[17] = encR(7, 8, 10, 0, 6'b100101);        // or  r10,r7,r8
    prog[18] = encR(8, 7, 11, 0, 6'b101010);        // slt r11,r8,r7
    prog[19] = encR(0, 7, 12, 3, 6'b000000);        // sll r12,r7,3
    prog[20] = encI(6'b001000, 0, 0, 55);           // addi r0,r0,55
    prog[21] = encR(0, 0, 13, 0, 6'b100000);        // add r13,r0,r0
    prog[22] = 32'hFC00_0000;                       // unknown opcode
    prog[23] = 32'h0000_0000;                       // all-zero word
    prog[24] = encJ(24);                            // j 96 (park)

    arstN = 1'b0; enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(pcOut == 32'd0, "R1", "pc in reset", pcOut, 32'd0);
    chk(dbgWe == 1'b0, "R9", "write strobe in reset", {31'd0, dbgWe}, 32'd0);
    arstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      dut_i.dpathI.imemArr[i] = prog[i];
      mImem[i] = prog[i];
    end
    for (int i = 0; i < 10; i++) begin
      dut_i.dpathI.dmemArr[i] = 32'(pairs[i]);
      mMem[i] = 32'(pairs[i]);
    end
    @(negedge clk);
    chk(pcOut == 32'd0, "R1", "pc after release", pcOut, 32'd0);

    for (int cyc = 0; cyc < 120; cyc++) begin
      bit we; logic [4:0] wa; logic [31:0] wd, npc, ins;
      string tag;
      enable = !(cyc >= 30 && cyc < 34);
      #1;
      predict(we, wa, wd, npc, ins);
      tag = !enable ? "R9" : (cyc < 2) ? "R1" : reqOf(ins);
      chk(pcOut == mPc, "R11", "pc", pcOut, mPc);
      chk(dbgWe == (enable && we), tag, "write strobe", {31'd0, dbgWe}, {31'd0, enable && we});
      if (enable && we) begin
        chk(dbgWaddr == wa, tag, "write address", {27'd0, dbgWaddr}, {27'd0, wa});
        chk(dbgWdata == wd, tag, "write data", dbgWdata, wd);
      end
      if (dbgWe && dbgWaddr != 0) seen[dbgWaddr] = dbgWdata;
      if (enable) modelStep();
      @(negedge clk);
    end

    enable = 1'b0;
    chk(seen[14] == 32'd0, "R1", "cleared registers combined", seen[14], 32'd0);
    chk(seen[15] == 32'd0, "R1", "unwritten data word", seen[15], 32'd0);
    chk(seen[6] == 32'(lastProd), "R3", "wrapped product", seen[6], 32'(lastProd));
    chk(seen[3] == 32'(expSum), "R3", "accumulated products", seen[3], 32'(expSum));
    chk(seen[7] == 32'(expSum), "R5", "store then load", seen[7], 32'(expSum));
    chk(seen[8] == 32'(-expSum), "R2", "subtract", seen[8], 32'(-expSum));
    chk(seen[11] == 32'd0, "R2", "signed compare", seen[11], 32'd0);
    chk(seen[12] == 32'(expSum) << 3, "R2", "shift left", seen[12], 32'(expSum) << 3);
    chk(seen[13] == 32'd0, "R8", "zero register after write", seen[13], 32'd0);
    chk(pcOut == 32'd96, "R7", "parked pc", pcOut, 32'd96);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule